// File: doc/BRIEF.md
# System Exception State and Control Registers

This block keeps the pending and active state of eight fixed system exceptions and presents it, together with a few related control registers, on a 32-bit word-addressed register bus. The eight exceptions are the non-maskable interrupt, the memory-management fault, the bus fault, the usage fault, the supervisor call, the debug monitor, the pended service call and the periodic tick. Sources inside the chip raise an exception by pulsing a set line. The core reports that an exception has been taken with an activate pulse and reports its return with a done pulse. Software can raise, and for two of the exceptions withdraw, pending state through the interrupt control/state word.

Each exception slot is a small state machine. Its four states are IDLE, PEND (pending only), ACT (active only) and ACT_PEND (active and pending again). From IDLE, a set moves the slot to PEND, an activate moves it to ACT, and both together move it to ACT_PEND. From PEND, an activate moves it to ACT, a clear returns it to IDLE, and a set keeps it in PEND. From ACT, a done returns it to IDLE, a set moves it to ACT_PEND, and a set with a done moves it to PEND. From ACT_PEND, a done moves it to PEND and a clear or an activate moves it to ACT. In every state a set outranks both clear and activate in the same cycle. The block also holds the vector table base, twelve handler priority bytes and the three fault-handler enables, and it raises a one-cycle reset request when the key-protected reset word is written. It does not prioritise or arbitrate.

Top module: `sysexc_ctl`

## Requirements
- R1: After reset all pending and active state, the fault enables, the vector base, all priority bytes and `reset_req_o` are zero.
- R2: A pulse on `set_pend_i[k]` makes `pend_o[k]` high from the next cycle. The slot order is 0 NMI (vector 2), 1 mem fault (4), 2 bus fault (5), 3 usage fault (6), 4 SVC (11), 5 debug monitor (12), 6 PendSV (14) and 7 SysTick (15).
- R3: A write of 1 to bit 31 of the control/state word (offset 0xD04) makes NMI pending.
- R4: In the control/state word, bit 28 sets PendSV pending and bit 27 clears it. When both are 1, the set wins.
- R5: In the control/state word, bit 26 sets SysTick pending and bit 25 clears it. When both are 1, the set wins.
- R6: A read of the control/state word returns the lowest pending vector number in bits 20:12, or 0 when nothing is pending. Bits 31, 28 and 26 return the pending flags of NMI, PendSV and SysTick. All other bits read 0.
- R7: An activate pulse makes a slot active and clears its pending flag, unless a set arrives in the same cycle. A done pulse clears the active flag. A slot that becomes pending while active stays pending.
- R8: A write to offset 0xD08 stores bits 31:7 of the data into the vector base. Bits 6:0 read as zero. The base is driven on `vtor_o`.
- R9: A write to offset 0xD0C with bits 31:16 equal to 0x05FA and bit 2 set raises `reset_req_o` for exactly the following cycle. Any other write there has no effect. The offset reads as zero.
- R10: A read of offset 0xD24 returns the active flags at bits 0 (mem), 1 (bus), 3 (usage), 7 (SVC), 8 (debug), 10 (PendSV) and 11 (SysTick), the pending flags at bits 12 (usage), 13 (mem) and 14 (bus), 15 (SVC), and the enables at bits 16 to 18.
- R11: A write to offset 0xD24 updates only the mem, bus and usage fault enables, from bits 16, 17 and 18. These drive `fault_en_o[0..2]`. The active and pending bits of that word ignore writes.
- R12: Offsets 0xD18, 0xD1C and 0xD20 each hold four priority bytes for handler vectors 4–7, 8–11 and 12–15, with the lowest vector in the least significant byte. The bytes read back unchanged and drive `prio_o`, with vector 4 in bits 7:0.
- R13: Writes to any other offset change nothing, and reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| set_pend_i | input | 8 | Per-slot set-pending pulses |
| exc_act_i | input | 8 | Per-slot "exception taken" pulses from the core |
| exc_done_i | input | 8 | Per-slot "exception returned" pulses from the core |
| pend_o | output | 8 | Per-slot pending flags |
| fault_en_o | output | 3 | Mem, bus and usage fault handler enables |
| vtor_o | output | 32 | Vector table base |
| reset_req_o | output | 1 | One-cycle system reset request |
| prio_o | output | 96 | Handler priority bytes, vectors 4 to 15 |

## Verification
The hardest cases are the ones where several sources act on the same slot in the same cycle. Examples are a software clear together with a software set, an activate together with a set, and a done together with a fresh pending request while the slot is still active. Directed sequences drive each of these collisions on purpose, for example a set and an activate in the same cycle on the bus-fault slot. A randomised phase then drives set, activate, done and register writes concurrently, so that these overlaps recur against a behavioural reference model. The reset key is reached both with a correct key and with near-miss keys, so that the single-cycle request pulse and its suppression are both observed.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
    localparam int NSLOT = 8;
    localparam int VEC_W = 9;

    localparam int SL_NMI     = 0;
    localparam int SL_MEM     = 1;
    localparam int SL_BUS     = 2;
    localparam int SL_USAGE   = 3;
    localparam int SL_SVC     = 4;
    localparam int SL_DEBUG   = 5;
    localparam int SL_PENDSV  = 6;
    localparam int SL_SYSTICK = 7;

    localparam int OFF_ICSR  = 'hD04;
    localparam int OFF_VTOR  = 'hD08;
    localparam int OFF_AIRCR = 'hD0C;
    localparam int OFF_PRIO  = 'hD18;
    localparam int OFF_SHCSR = 'hD24;

    localparam logic [15:0] RESET_KEY = 16'h05FA;

    typedef enum logic [1:0] {
        SX_IDLE     = 2'b00,
        SX_PEND     = 2'b01,
        SX_ACT      = 2'b10,
        SX_ACT_PEND = 2'b11
    } sx_state_e;

    function automatic logic [VEC_W-1:0] vec_of(input int slot);
        case (slot)
            SL_NMI:     vec_of = VEC_W'(2);
            SL_MEM:     vec_of = VEC_W'(4);
            SL_BUS:     vec_of = VEC_W'(5);
            SL_USAGE:   vec_of = VEC_W'(6);
            SL_SVC:     vec_of = VEC_W'(11);
            SL_DEBUG:   vec_of = VEC_W'(12);
            SL_PENDSV:  vec_of = VEC_W'(14);
            default:    vec_of = VEC_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/sysexc_slot.sv
module sysexc_slot
    import sysexc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic act_i,
    input  logic done_i,
    output logic pend_o,
    output logic act_o
);
    sx_state_e state_q, state_d;
    logic      pend_n, act_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_n = set_i | (pend_o & ~clr_i & ~act_i);
        act_n  = act_i | (act_o & ~done_i);
        unique case ({act_n, pend_n})
            2'b00:   state_d = SX_IDLE;
            2'b01:   state_d = SX_PEND;
            2'b10:   state_d = SX_ACT;
            default: state_d = SX_ACT_PEND;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SX_IDLE:     begin pend_o = 1'b0; act_o = 1'b0; end
            SX_PEND:     begin pend_o = 1'b1; act_o = 1'b0; end
            SX_ACT:      begin pend_o = 1'b0; act_o = 1'b1; end
            default:     begin pend_o = 1'b1; act_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/sysexc_lowpend.sv
module sysexc_lowpend
    import sysexc_pkg::*;
(
    input  logic [NSLOT-1:0] pend_i,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        vec_o = '0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (pend_i[k]) vec_o = vec_of(k);
        end
    end
endmodule

// File: rtl/sysexc_prio.sv
module sysexc_prio #(
    parameter int ADDR_W = 12,
    parameter int NWORD  = 3,
    parameter int BASE   = 'hD18,
    localparam int FLAT_W = NWORD * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [FLAT_W-1:0] prio_o,
    output logic              hit_o,
    output logic [31:0]       rdata_o
);
    logic [NWORD-1:0] hit;

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign hit[w] = (addr_i == ADDR_W'(BASE + 4 * w));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              prio_o[w*32 +: 32] <= '0;
            else if (wr_i && hit[w]) prio_o[w*32 +: 32] <= wdata_i;
        end
    end

    assign hit_o = |hit;

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (hit[w]) rdata_o = prio_o[w*32 +: 32];
        end
    end
endmodule

// File: rtl/sysexc_ctl.sv
module sysexc_ctl
    import sysexc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PRIO_WORDS = 3,
    localparam int PRIO_W    = PRIO_WORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSLOT-1:0]  set_pend_i,
    input  logic [NSLOT-1:0]  exc_act_i,
    input  logic [NSLOT-1:0]  exc_done_i,
    output logic [NSLOT-1:0]  pend_o,
    output logic [2:0]        fault_en_o,
    output logic [31:0]       vtor_o,
    output logic              reset_req_o,
    output logic [PRIO_W-1:0] prio_o
);
    localparam logic [ADDR_W-1:0] A_ICSR  = ADDR_W'(OFF_ICSR);
    localparam logic [ADDR_W-1:0] A_VTOR  = ADDR_W'(OFF_VTOR);
    localparam logic [ADDR_W-1:0] A_AIRCR = ADDR_W'(OFF_AIRCR);
    localparam logic [ADDR_W-1:0] A_SHCSR = ADDR_W'(OFF_SHCSR);

    logic [NSLOT-1:0] sw_set, sw_clr, act_q;
    logic [VEC_W-1:0] low_vec;
    logic             wr_icsr, prio_hit;
    logic [31:0]      prio_rd;

    assign wr_icsr = bus_wr && (bus_addr == A_ICSR);

    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        sw_set[SL_NMI]     = wr_icsr & bus_wdata[31];
        sw_set[SL_PENDSV]  = wr_icsr & bus_wdata[28];
        sw_clr[SL_PENDSV]  = wr_icsr & bus_wdata[27];
        sw_set[SL_SYSTICK] = wr_icsr & bus_wdata[26];
        sw_clr[SL_SYSTICK] = wr_icsr & bus_wdata[25];
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        sysexc_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_pend_i[k] | sw_set[k]),
            .clr_i  (sw_clr[k]),
            .act_i  (exc_act_i[k]),
            .done_i (exc_done_i[k]),
            .pend_o (pend_o[k]),
            .act_o  (act_q[k])
        );
    end

    sysexc_lowpend u_low (
        .pend_i (pend_o),
        .vec_o  (low_vec)
    );

    sysexc_prio #(
        .ADDR_W (ADDR_W),
        .NWORD  (PRIO_WORDS),
        .BASE   (OFF_PRIO)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .prio_o  (prio_o),
        .hit_o   (prio_hit),
        .rdata_o (prio_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vtor_o      <= '0;
            fault_en_o  <= '0;
            reset_req_o <= 1'b0;
        end else begin
            reset_req_o <= bus_wr && (bus_addr == A_AIRCR)
                           && (bus_wdata[31:16] == RESET_KEY) && bus_wdata[2];
            if (bus_wr && bus_addr == A_VTOR)  vtor_o     <= {bus_wdata[31:7], 7'b0};
            if (bus_wr && bus_addr == A_SHCSR) fault_en_o <= bus_wdata[18:16];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ICSR: begin
                bus_rdata[31]    = pend_o[SL_NMI];
                bus_rdata[28]    = pend_o[SL_PENDSV];
                bus_rdata[26]    = pend_o[SL_SYSTICK];
                bus_rdata[20:12] = low_vec;
            end
            A_VTOR: bus_rdata = vtor_o;
            A_SHCSR: begin
                bus_rdata[0]     = act_q[SL_MEM];
                bus_rdata[1]     = act_q[SL_BUS];
                bus_rdata[3]     = act_q[SL_USAGE];
                bus_rdata[7]     = act_q[SL_SVC];
                bus_rdata[8]     = act_q[SL_DEBUG];
                bus_rdata[10]    = act_q[SL_PENDSV];
                bus_rdata[11]    = act_q[SL_SYSTICK];
                bus_rdata[12]    = pend_o[SL_USAGE];
                bus_rdata[13]    = pend_o[SL_MEM];
                bus_rdata[14]    = pend_o[SL_BUS];
                bus_rdata[15]    = pend_o[SL_SVC];
                bus_rdata[18:16] = fault_en_o;
            end
            default: bus_rdata = prio_hit ? prio_rd : '0;
        endcase
    end
endmodule

// File: rtl/sysexc_ctl_chk.sv
module sysexc_ctl_chk
    import sysexc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NSLOT-1:0]  set_pend_i,
    input logic [NSLOT-1:0]  exc_act_i,
    input logic [NSLOT-1:0]  pend_o,
    input logic [2:0]        fault_en_o,
    input logic [31:0]       vtor_o,
    input logic              reset_req_o
);
    // R2
    set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pend_i != '0) |=> ((pend_o & $past(set_pend_i)) == $past(set_pend_i)));

    // R7
    act_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_act_i[SL_USAGE] && !set_pend_i[SL_USAGE]) |=> !pend_o[SL_USAGE]);

    // R4
    pendsv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_ICSR) && bus_wdata[28]) |=> pend_o[SL_PENDSV]);

    // R9
    reset_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_AIRCR)
                              && bus_wdata[31:16] == RESET_KEY && bus_wdata[2]));

    // R8
    vtor_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_VTOR)) |=> (vtor_o[31:7] == $past(bus_wdata[31:7])));

    // R11
    fault_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFF_SHCSR)) |=> $stable(fault_en_o));
endmodule

bind sysexc_ctl sysexc_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .set_pend_i  (set_pend_i),
    .exc_act_i   (exc_act_i),
    .pend_o      (pend_o),
    .fault_en_o  (fault_en_o),
    .vtor_o      (vtor_o),
    .reset_req_o (reset_req_o)
);

// File: tb/sysexc_ctl_tb.sv
`timescale 1ns/1ps
module sysexc_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  set_pend_i = '0, exc_act_i = '0, exc_done_i = '0;
    logic [7:0]  pend_o;
    logic [2:0]  fault_en_o;
    logic [31:0] vtor_o;
    logic        reset_req_o;
    logic [95:0] prio_o;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sysexc_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_pend_i(set_pend_i),
        .exc_act_i(exc_act_i), .exc_done_i(exc_done_i), .pend_o(pend_o),
        .fault_en_o(fault_en_o), .vtor_o(vtor_o), .reset_req_o(reset_req_o),
        .prio_o(prio_o)
    );

    // behavioural reference model
    logic [7:0]  m_pend, m_act;
    logic [2:0]  m_en;
    logic [31:0] m_vtor;
    logic [95:0] m_prio;
    logic        m_rreq;
    int          vecs [8] = '{2, 4, 5, 6, 11, 12, 14, 15};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_act = 0; m_en = 0; m_vtor = 0; m_prio = 0; m_rreq = 0;
        end else begin
            logic [7:0] s, c;
            s = set_pend_i; c = 0;
            if (bus_wr && bus_addr == 12'hD04) begin
                if (bus_wdata[31]) s[0] = 1;
                if (bus_wdata[28]) s[6] = 1;
                if (bus_wdata[27]) c[6] = 1;
                if (bus_wdata[26]) s[7] = 1;
                if (bus_wdata[25]) c[7] = 1;
            end
            for (int k = 0; k < 8; k++) begin
                if (s[k]) m_pend[k] = 1;
                else if (c[k] || exc_act_i[k]) m_pend[k] = 0;
                if (exc_act_i[k]) m_act[k] = 1;
                else if (exc_done_i[k]) m_act[k] = 0;
            end
            m_rreq = bus_wr && bus_addr == 12'hD0C && bus_wdata[31:16] == 16'h05FA && bus_wdata[2];
            if (bus_wr) begin
                case (bus_addr)
                    12'hD08: m_vtor = bus_wdata & 32'hFFFF_FF80;
                    12'hD24: m_en = bus_wdata[18:16];
                    12'hD18: m_prio[31:0]  = bus_wdata;
                    12'hD1C: m_prio[63:32] = bus_wdata;
                    12'hD20: m_prio[95:64] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] mread(input logic [11:0] a);
        logic [31:0] r;
        r = 0;
        case (a)
            12'hD04: begin
                r[31] = m_pend[0]; r[28] = m_pend[6]; r[26] = m_pend[7];
                for (int k = 7; k >= 0; k--) if (m_pend[k]) r[20:12] = vecs[k];
            end
            12'hD08: r = m_vtor;
            12'hD18: r = m_prio[31:0];
            12'hD1C: r = m_prio[63:32];
            12'hD20: r = m_prio[95:64];
            12'hD24: begin
                r[0] = m_act[1]; r[1] = m_act[2]; r[3] = m_act[3]; r[7] = m_act[4];
                r[8] = m_act[5]; r[10] = m_act[6]; r[11] = m_act[7];
                r[12] = m_pend[3]; r[13] = m_pend[1]; r[14] = m_pend[2]; r[15] = m_pend[4];
                r[18:16] = m_en;
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string rtag(input logic [11:0] a);
        case (a)
            12'hD04: return "R6";
            12'hD08: return "R8";
            12'hD0C: return "R9";
            12'hD18, 12'hD1C, 12'hD20: return "R12";
            12'hD24: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        chk(pend_o == m_pend, "R7", pend_o, m_pend);
        chk(fault_en_o == m_en, "R11", fault_en_o, m_en);
        chk(vtor_o == m_vtor, "R8", vtor_o, m_vtor);
        chk(reset_req_o == m_rreq, "R9", reset_req_o, m_rreq);
        chk(prio_o == m_prio, "R12", prio_o, m_prio);
        chk(bus_rdata == mread(bus_addr), rtag(bus_addr), bus_rdata, mread(bus_addr));
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic pset(input logic [7:0] v);  set_pend_i = v; tick(); set_pend_i = 0; endtask
    task automatic pact(input logic [7:0] v);  exc_act_i = v;  tick(); exc_act_i = 0;  endtask
    task automatic pdone(input logic [7:0] v); exc_done_i = v; tick(); exc_done_i = 0; endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R1 reset state
        chk(pend_o == 0, "R1", pend_o, 0);
        chk(fault_en_o == 0, "R1", fault_en_o, 0);
        chk(vtor_o == 0, "R1", vtor_o, 0);
        chk(prio_o == 0, "R1", prio_o, 0);
        chk(reset_req_o == 0, "R1", reset_req_o, 0);
        rd(12'hD04, 32'h0, "R1");

        // R2 internal set pulses on mem and bus
        pset(8'h06);
        chk(pend_o == 8'h06, "R2", pend_o, 8'h06);
        rd(12'hD04, 32'h0000_4000, "R6");
        rd(12'hD24, 32'h0000_6000, "R10");
        // R7 activation clears pending
        pact(8'h02);
        chk(pend_o == 8'h04, "R7", pend_o, 8'h04);
        rd(12'hD24, 32'h0000_4001, "R7");
        rd(12'hD04, 32'h0000_5000, "R6");
        pset(8'h02);
        chk(pend_o == 8'h06, "R7", pend_o, 8'h06);
        pdone(8'h02);
        rd(12'hD24, 32'h0000_6000, "R7");
        pact(8'h06);
        pdone(8'h06);
        rd(12'hD24, 32'h0, "R7");

        // R3 NMI by software
        wr(12'hD04, 32'h8000_0000);
        chk(pend_o == 8'h01, "R3", pend_o, 8'h01);
        rd(12'hD04, 32'h8000_2000, "R6");
        pact(8'h01); pdone(8'h01);

        // R4 PendSV set wins over clear
        wr(12'hD04, 32'h1800_0000);
        chk(pend_o == 8'h40, "R4", pend_o, 8'h40);
        rd(12'hD04, 32'h1000_E000, "R6");
        wr(12'hD04, 32'h0800_0000);
        chk(pend_o == 8'h00, "R4", pend_o, 8'h00);

        // R5 SysTick set wins over clear
        wr(12'hD04, 32'h0600_0000);
        chk(pend_o == 8'h80, "R5", pend_o, 8'h80);
        rd(12'hD04, 32'h0400_F000, "R6");
        wr(12'hD04, 32'h0200_0000);
        chk(pend_o == 8'h00, "R5", pend_o, 8'h00);

        // R8 vector base
        wr(12'hD08, 32'hFFFF_FFFF);
        chk(vtor_o == 32'hFFFF_FF80, "R8", vtor_o, 32'hFFFF_FF80);
        wr(12'hD08, 32'h1234_5678);
        rd(12'hD08, 32'h1234_5600, "R8");

        // R9 key-protected reset request
        wr(12'hD0C, 32'h05FB_0004);
        chk(reset_req_o == 0, "R9", reset_req_o, 0);
        wr(12'hD0C, 32'h05FA_0000);
        chk(reset_req_o == 0, "R9", reset_req_o, 0);
        wr(12'hD0C, 32'h05FA_0004);
        chk(reset_req_o == 1, "R9", reset_req_o, 1);
        tick();
        chk(reset_req_o == 0, "R9", reset_req_o, 0);
        rd(12'hD0C, 32'h0, "R9");

        // R11 handler control write touches enables only
        pset(8'h10);
        pact(8'h20);
        wr(12'hD24, 32'hFFFF_FFFF);
        chk(fault_en_o == 3'b111, "R11", fault_en_o, 3'b111);
        rd(12'hD24, 32'h0007_8100, "R11");
        wr(12'hD24, 32'h0000_0000);
        rd(12'hD24, 32'h0000_8100, "R11");
        pact(8'h10);
        pdone(8'h30);

        // R12 priority bytes
        wr(12'hD18, 32'h4433_2211);
        wr(12'hD1C, 32'h8877_6655);
        wr(12'hD20, 32'hCCBB_AA99);
        chk(prio_o == 96'hCCBBAA99_88776655_44332211, "R12", prio_o, 96'hCCBBAA99_88776655_44332211);
        rd(12'hD1C, 32'h8877_6655, "R12");

        // R13 reserved offsets
        wr(12'hD10, 32'hFFFF_FFFF);
        chk(pend_o == 0 && fault_en_o == 0, "R13", {pend_o, fault_en_o}, 0);
        chk(vtor_o == 32'h1234_5600, "R13", vtor_o, 32'h1234_5600);
        rd(12'hD10, 32'h0, "R13");
        rd(12'hD00, 32'h0, "R13");

        // R7 set and activation in one cycle
        set_pend_i = 8'h04; exc_act_i = 8'h04;
        tick();
        set_pend_i = 0; exc_act_i = 0;
        chk(pend_o == 8'h04, "R7", pend_o, 8'h04);
        rd(12'hD24, 32'h0000_4002, "R7");
        pact(8'h04); pdone(8'h04);

        // randomised overlap phase against the model
        for (int i = 0; i < 600; i++) begin
            logic [11:0] alist [9];
            alist = '{12'hD04, 12'hD08, 12'hD0C, 12'hD18, 12'hD1C, 12'hD20, 12'hD24, 12'hD10, 12'hD00};
            set_pend_i = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
            exc_act_i  = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
            exc_done_i = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
            bus_wr     = ($urandom % 2 == 0);
            bus_addr   = alist[$urandom % 9];
            bus_wdata  = $urandom;
            if (bus_addr == 12'hD0C && ($urandom % 2 == 0)) bus_wdata[31:16] = 16'h05FA;
            tick();
        end
        bus_wr = 0; set_pend_i = 0; exc_act_i = 0; exc_done_i = 0;
        tick();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule